// File: doc/BRIEF.md
# Multiphase Round-Robin Phase Activator

This block decides which phase of a multiphase buck converter may start its next charging cycle. Outside high load, one activation token moves round-robin across the phases. The holder's `act_o` bit is high. The holder samples the synchronised voltage flags and resolves a mode: under-voltage or over-voltage. It then sends a one-cycle start request to its own charge controller, or a sink request when the mode is over-voltage. Resolving a mode releases the token at once: the stage does not wait for the charge to finish. The token still stays at least a parameterised dwell time before it moves on. While under-voltage persists, each phase in turn starts a charge and helps the phases before it.

A high-load flag overrides the rotation. Every phase is activated together. On entry, every phase that is not busy receives a charge start, because high load implies under-voltage. When high load clears, rotation resumes at the phase after the last token holder, with a fresh dwell period.

Top module: `phase_activator`

## Requirements
- R1: After reset the token is at phase 0, `act_o` equals 1 on bit 0 only, `mode_o` shows idle (bit 0), and no start or sink pulse is issued.
- R2: Outside high load exactly one `act_o` bit is high, and the token visits phases in the order 0, 1, ..., NUM_PHASES-1, then wraps to 0.
- R3: A stage keeps the token for at least DWELL_CYCLES cycles. It passes the token only after it has resolved a mode, on the first clock edge at which both conditions hold.
- R4: A stage with no resolved mode and its `busy_i` bit low samples the flags at a clock edge. On that edge it raises either `sink_start_o` or `charge_start_o` for its own phase, for one cycle. While `busy_i` of the holder is high, nothing is resolved.
- R5: When under-voltage and over-voltage are both seen at resolution, over-voltage wins: a sink pulse is issued, not a charge pulse.
- R6: `mode_o` is one-hot with bit 0 idle, bit 1 under-voltage and bit 2 over-voltage. It shows the current stage's mode and returns to idle when the token passes.
- R7: With under-voltage held and no phase busy, consecutive stages each issue one charge pulse, one every DWELL_CYCLES cycles.
- R8: The cycle after `hl_i` is sampled high, all `act_o` bits are high. On the entry edge, if `uv_i` is high, every phase whose `busy_i` bit is low gets a charge pulse, and the mode becomes under-voltage.
- R9: The token does not move during high load. After `hl_i` falls, the token moves to the phase after the last holder, with the dwell restarted and the mode idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hl_i | input | 1 | Synchronised high-load flag |
| uv_i | input | 1 | Synchronised under-voltage flag |
| ov_i | input | 1 | Synchronised over-voltage flag |
| busy_i | input | NUM_PHASES | Per-phase charge controller busy |
| act_o | output | NUM_PHASES | Per-phase activation |
| charge_start_o | output | NUM_PHASES | One-cycle charge start request per phase |
| sink_start_o | output | NUM_PHASES | One-cycle over-voltage sink request per phase |
| mode_o | output | 3 | One-hot mode: idle, under-voltage, over-voltage |

## Verification
Several properties are checked on every clock cycle. There is a single activation outside high load, and the full broadcast during high load. `mode_o` stays one-hot. Start and sink pulses never occur together, and each targets the active phase. Any token move outside high load follows an expired dwell and a resolved mode. Other behaviours need scenarios to show them. These include the exact rotation order, the deferral while a phase is busy, the priority of over-voltage, and the resume point after high load. A cycle-level reference model in the bench covers them under directed and random flag patterns.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_UV   = 2'd1,
        MODE_OV   = 2'd2
    } mode_e;
endpackage

// File: rtl/pa_mode_arb.sv
module pa_mode_arb
    import pa_pkg::*;
(
    input  logic  enable_i,
    input  logic  uv_i,
    input  logic  ov_i,
    output mode_e pick_o
);
    always_comb begin
        pick_o = MODE_IDLE;
        if (enable_i) begin
            if (ov_i) begin
                pick_o = MODE_OV;
            end else if (uv_i) begin
                pick_o = MODE_UV;
            end
        end
    end
endmodule

// File: rtl/pa_onehot.sv
module pa_onehot #(
    parameter int NUM = 4,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [IW-1:0]  idx_i,
    output logic [NUM-1:0] vec_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_bit
        assign vec_o[g] = (idx_i == IW'(g));
    end
endmodule

// File: rtl/phase_activator.sv
module phase_activator
    import pa_pkg::*;
#(
    parameter int NUM_PHASES   = 4,
    parameter int DWELL_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hl_i,
    input  logic                  uv_i,
    input  logic                  ov_i,
    input  logic [NUM_PHASES-1:0] busy_i,
    output logic [NUM_PHASES-1:0] act_o,
    output logic [NUM_PHASES-1:0] charge_start_o,
    output logic [NUM_PHASES-1:0] sink_start_o,
    output logic [2:0]            mode_o
);
    localparam int IDX_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
    localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] DWELL_LAST = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(NUM_PHASES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]      token;
        logic [CNT_W-1:0]      cnt;
        mode_e                 mode;
        logic                  hl;
        logic [NUM_PHASES-1:0] start;
        logic [NUM_PHASES-1:0] sink;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_PHASES-1:0] tok_vec;
    mode_e                 pick;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] cur);
        return (cur == IDX_LAST) ? '0 : cur + 1'b1;
    endfunction

    pa_onehot #(.NUM(NUM_PHASES)) i_tok_dec (
        .idx_i (st_q.token),
        .vec_o (tok_vec)
    );

    pa_mode_arb i_arb (
        .enable_i (st_q.mode == MODE_IDLE && !busy_i[st_q.token]),
        .uv_i     (uv_i),
        .ov_i     (ov_i),
        .pick_o   (pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = '0;
        st_d.sink  = '0;
        if (hl_i) begin
            st_d.hl = 1'b1;
            if (!st_q.hl) begin
                st_d.cnt  = '0;
                st_d.mode = uv_i ? MODE_UV : MODE_IDLE;
                if (uv_i) begin
                    st_d.start = ~busy_i;
                end
            end
        end else if (st_q.hl) begin
            st_d.hl    = 1'b0;
            st_d.token = next_idx(st_q.token);
            st_d.cnt   = '0;
            st_d.mode  = MODE_IDLE;
        end else if (st_q.mode != MODE_IDLE && st_q.cnt == DWELL_LAST) begin
            st_d.token = next_idx(st_q.token);
            st_d.cnt   = '0;
            st_d.mode  = MODE_IDLE;
        end else begin
            if (st_q.cnt != DWELL_LAST) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.mode == MODE_IDLE) begin
                st_d.mode = pick;
                if (pick == MODE_OV) begin
                    st_d.sink = tok_vec;
                end else if (pick == MODE_UV) begin
                    st_d.start = tok_vec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{token: '0, cnt: '0, mode: MODE_IDLE, hl: 1'b0,
                      start: '0, sink: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o          = st_q.hl ? {NUM_PHASES{1'b1}} : tok_vec;
    assign charge_start_o = st_q.start;
    assign sink_start_o   = st_q.sink;
    assign mode_o         = {st_q.mode == MODE_OV, st_q.mode == MODE_UV,
                             st_q.mode == MODE_IDLE};

    assert_single_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.hl |-> $onehot(act_o));

    assert_dwell_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.hl && !$past(st_q.hl) && st_q.token != $past(st_q.token))
        |-> ($past(st_q.cnt) == DWELL_LAST && $past(st_q.mode) != MODE_IDLE));

    assert_pulse_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !((|charge_start_o) && (|sink_start_o)));

    assert_sink_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|sink_start_o) |-> (sink_start_o == act_o));

    assert_charge_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|charge_start_o) && !st_q.hl) |-> (charge_start_o == act_o));

    assert_mode_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(mode_o));

    assert_broadcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hl |-> (&act_o));
endmodule

// File: tb/test_phase_activator.sv
`timescale 1ns/1ps
module test_phase_activator;
    localparam int N  = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hl = 1'b0, uv = 1'b0, ov = 1'b0;
    logic [N-1:0] busy = '0;
    logic [N-1:0] act, cstart, sstart;
    logic [2:0]   mode;

    int checks = 0;
    int errors = 0;
    int cnt_charge = 0;
    int cnt_sink = 0;

    // reference model state, mode code 0 idle 1 uv 2 ov
    int m_tok = 0, m_cnt = 0, m_mode = 0;
    bit m_hl = 0;
    logic [N-1:0] m_start = '0, m_sink = '0;

    always #5 clk = ~clk;

    phase_activator #(.NUM_PHASES(N), .DWELL_CYCLES(DW)) i_phase_activator (
        .clk(clk), .rst_n(rst_n), .hl_i(hl), .uv_i(uv), .ov_i(ov),
        .busy_i(busy), .act_o(act), .charge_start_o(cstart),
        .sink_start_o(sstart), .mode_o(mode)
    );

    always @(posedge clk or negedge rst_n) begin
        int tok, cnt, md;
        bit h;
        logic [N-1:0] st, sk;
        if (!rst_n) begin
            m_tok = 0; m_cnt = 0; m_mode = 0; m_hl = 0; m_start = '0; m_sink = '0;
        end else begin
            tok = m_tok; cnt = m_cnt; md = m_mode; h = m_hl; st = '0; sk = '0;
            if (hl) begin
                if (!m_hl) begin
                    cnt = 0;
                    md = uv ? 1 : 0;
                    if (uv) st = ~busy;
                end
                h = 1;
            end else if (m_hl) begin
                h = 0; tok = (m_tok + 1) % N; cnt = 0; md = 0;
            end else if (m_mode != 0 && m_cnt == DW - 1) begin
                tok = (m_tok + 1) % N; cnt = 0; md = 0;
            end else begin
                if (m_cnt < DW - 1) cnt = m_cnt + 1;
                if (m_mode == 0 && !busy[m_tok]) begin
                    if (ov) begin md = 2; sk[m_tok] = 1'b1; end
                    else if (uv) begin md = 1; st[m_tok] = 1'b1; end
                end
            end
            m_tok = tok; m_cnt = cnt; m_mode = md; m_hl = h; m_start = st; m_sink = sk;
        end
    end

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] e_act;
        e_act = m_hl ? {N{1'b1}} : N'(1) << m_tok;
        check("R2 R3 R9 act", act, e_act);
        check("R4 R7 R8 charge", cstart, m_start);
        check("R4 R5 sink", sstart, m_sink);
        check("R6 mode", N'(mode), N'(3'(1) << m_mode));
        cnt_charge += $countones(cstart);
        cnt_sink   += $countones(sstart);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hl_left;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 act", act, 4'b0001);
        check("R1 mode", N'(mode), 4'b0001);
        check("R1 pulses", cstart | sstart, '0);
        run(3);
        // R7: persistent under-voltage, consecutive phases charge
        uv = 1'b1;
        cnt_charge = 0;
        run(5 * DW);
        checks++;
        if (cnt_charge < 4) begin
            errors++;
            $display("FAIL R7: actual %0d charge pulses expected >= 4", cnt_charge);
        end
        // R5: both flags present, over-voltage wins
        ov = 1'b1;
        cnt_sink = 0; cnt_charge = 0;
        run(3 * DW);
        checks++;
        if (cnt_sink < 2 || cnt_charge != 0) begin
            errors++;
            $display("FAIL R5: actual sink %0d charge %0d expected sink >= 2 charge 0",
                     cnt_sink, cnt_charge);
        end
        ov = 1'b0;
        // R4: busy holder defers resolution
        busy = '1;
        run(2 * DW);
        busy = '0;
        run(DW);
        // R8 R9: high-load broadcast with one busy phase, then resume
        busy = 4'b0100;
        hl = 1'b1;
        run(6);
        hl = 1'b0;
        busy = '0;
        run(3 * DW);
        // random mix
        hl_left = 0;
        for (int i = 0; i < 3000; i++) begin
            if (hl_left > 0) begin
                hl_left--;
                hl = 1'b1;
            end else begin
                hl = ($urandom_range(99) < 2);
                if (hl) hl_left = $urandom_range(12);
            end
            uv = hl ? 1'b1 : ($urandom_range(99) < 50);
            ov = hl ? 1'b0 : ($urandom_range(99) < 15);
            for (int b = 0; b < N; b++) busy[b] = ($urandom_range(99) < 20);
            run(1);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule